// File: doc/BRIEF.md
# Read Data Parity Status Checker

This block sits beside the data path of a 32-bit bus master and checks per-byte parity on the data that a read cycle returns. A small state machine follows each bus cycle from its first clock to the clock in which the ready strobe completes it. When a read cycle completes, the byte lanes that actually carried data are checked. The result appears on an active-low status output for exactly one clock, the clock after the ready clock.

A lane takes part in the check only if its byte enable is set and the lane exists on the port size reported for the cycle. An 8-bit port carries only the lowest enabled lane. A 16-bit port carries only the enabled lanes of one half-word. Write cycles and idle clocks never report an error. A three-state test input turns off the output enable of the status pin.

The state machine has three states:
- S_IDLE: no cycle is running. A clock with the cycle-active flag set is the first clock of a cycle.
- S_RD_WAIT: a read cycle is waiting for ready.
- S_WR_WAIT: a write cycle is waiting for ready.

It has these transitions:
- START_RD: S_IDLE to S_RD_WAIT, taken when the cycle-active flag is set and the direction is read.
- START_WR: S_IDLE to S_WR_WAIT, taken when the cycle-active flag is set and the direction is write.
- COMPLETE: either wait state to S_IDLE, taken when ready is low and the cycle is still active.
- ABORT: either wait state to S_IDLE, taken when the cycle-active flag drops before ready.

Top module: `rd_parity_status`

## Requirements
- R1: While reset is high, and in the first clock after it, `pchk_n` is 1 and `pchk_oe` is 1.
- R2: When a read cycle completes (ready low in a clock after the cycle's first clock), `pchk_n` is 0 in the next clock if any checked lane fails parity. Otherwise it is 1.
- R3: Parity is even per lane. Lane i is data bits [8i+7:8i] plus `rpar[i]`, and it fails when those nine bits hold an odd number of ones.
- R4: With both size inputs low (32-bit port), exactly the lanes whose `be` bit is 1 are checked. With `be` all zero, no error is reported.
- R5: With `size8` high, only the lowest-numbered lane whose `be` bit is 1 is checked. `size8` takes priority over `size16`.
- R6: With `size16` high and `size8` low, lanes 0 and 1 form the lower half-word and lanes 2 and 3 the upper. If `be[1:0]` is non-zero, only enabled lanes of the lower half are checked. Otherwise only enabled lanes of the upper half are checked.
- R7: Ready is ignored while `bus_active` is low and in the first clock of a cycle. It produces no status and does not complete the cycle.
- R8: A cycle whose `is_write` is 1 in its first clock never drives `pchk_n` low.
- R9: `pchk_n` is low for at most one clock at a time and is 1 in every clock other than the one after a read completes.
- R10: `pchk_oe` is 0 in the clock after `test_hiz` is sampled 1, and 1 in the clock after it is sampled 0.
- R11: If `bus_active` drops before ready, the cycle ends with no status. The next active clock is the first clock of a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_active | input | 1 | High during every clock of a bus cycle |
| is_write | input | 1 | Cycle direction, 1 = write; sampled in the first clock |
| rdy_n | input | 1 | Ready strobe, active low |
| be | input | LANES | Byte enables, active high, bit i = lane i |
| size8 | input | 1 | Port is 8 bits wide for this cycle |
| size16 | input | 1 | Port is 16 bits wide for this cycle |
| rdata | input | 8*LANES | Read data, lane i in bits [8i+7:8i] |
| rpar | input | LANES | Parity bit per lane |
| test_hiz | input | 1 | Three-state test mode request |
| pchk_n | output | 1 | Parity status, low = error, registered |
| pchk_oe | output | 1 | Output enable of the status pin, registered |

## Verification
The bench builds the block with the default of four lanes. This keeps the sweep small enough to run in full: all sixteen byte-enable patterns, under every port-size combination including both size inputs high, in both directions, with no error or a single error placed on each lane in turn. Errors alternate between a flipped parity bit and a flipped data bit, so both halves of the even-parity rule are exercised. Wait states, an early ready in the first clock, ready while idle, an aborted cycle and test-mode toggling cover the timing rules.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RD_WAIT = 2'd1,
        S_WR_WAIT = 2'd2
    } bus_state_t;

endpackage

// File: rtl/prs_lane_select.sv
module prs_lane_select
    import prs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] be,
    input  logic             size8,
    input  logic             size16,
    output logic [LANES-1:0] sel
);
    localparam int GROUP  = HALF_W / BYTE_W;
    localparam int GROUPS = LANES / GROUP;

    logic [LANES-1:0] sel8;
    logic [LANES-1:0] sel16;
    logic             found8;
    logic             found16;

    // lowest enabled lane for an 8-bit port
    always_comb begin
        sel8   = '0;
        found8 = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (be[i] && !found8) begin
                sel8[i] = 1'b1;
                found8  = 1'b1;
            end
        end
    end

    // lowest half-word with any enable for a 16-bit port
    always_comb begin
        sel16   = '0;
        found16 = 1'b0;
        for (int g = 0; g < GROUPS; g++) begin
            if (!found16 && (|be[g*GROUP +: GROUP])) begin
                sel16[g*GROUP +: GROUP] = be[g*GROUP +: GROUP];
                found16 = 1'b1;
            end
        end
    end

    always_comb begin
        if (size8) begin
            sel = sel8;
        end else if (size16) begin
            sel = sel16;
        end else begin
            sel = be;
        end
    end

endmodule

// File: rtl/prs_lane_parity.sv
module prs_lane_parity
    import prs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*BYTE_W-1:0] data,
    input  logic [LANES-1:0]        par,
    output logic [LANES-1:0]        bad
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bad[i] = ^{data[i*BYTE_W +: BYTE_W], par[i]};
    end

endmodule

// File: rtl/rd_parity_status.sv
module rd_parity_status
    import prs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_active,
    input  logic                    is_write,
    input  logic                    rdy_n,
    input  logic [LANES-1:0]        be,
    input  logic                    size8,
    input  logic                    size16,
    input  logic [LANES*BYTE_W-1:0] rdata,
    input  logic [LANES-1:0]        rpar,
    input  logic                    test_hiz,
    output logic                    pchk_n,
    output logic                    pchk_oe
);
    bus_state_t       state_q;
    bus_state_t       state_d;
    logic [LANES-1:0] lane_sel;
    logic [LANES-1:0] lane_bad;
    logic             rd_done;
    logic             lane_err;
    logic             pchk_n_q;
    logic             pchk_oe_q;

    prs_lane_select #(.LANES(LANES)) u_sel (
        .be     (be),
        .size8  (size8),
        .size16 (size16),
        .sel    (lane_sel)
    );

    prs_lane_parity #(.LANES(LANES)) u_par (
        .data (rdata),
        .par  (rpar),
        .bad  (lane_bad)
    );

    assign lane_err = |(lane_sel & lane_bad);

    // next state: START_RD, START_WR, COMPLETE, ABORT
    always_comb begin
        state_d = state_q;
        rd_done = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (bus_active) begin
                    state_d = is_write ? S_WR_WAIT : S_RD_WAIT;
                end
            end
            S_RD_WAIT: begin
                if (!bus_active) begin
                    state_d = S_IDLE;
                end else if (!rdy_n) begin
                    state_d = S_IDLE;
                    rd_done = 1'b1;
                end
            end
            S_WR_WAIT: begin
                if (!bus_active || !rdy_n) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            pchk_n_q  <= 1'b1;
            pchk_oe_q <= 1'b1;
        end else begin
            pchk_n_q  <= !(rd_done && lane_err);
            pchk_oe_q <= !test_hiz;
        end
    end

    assign pchk_n  = pchk_n_q;
    assign pchk_oe = pchk_oe_q;

endmodule

// File: rtl/rd_parity_status_chk.sv
module rd_parity_status_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_active,
    input logic             rdy_n,
    input logic [LANES-1:0] be,
    input logic             test_hiz,
    input logic             pchk_n,
    input logic             pchk_oe
);
    p_reset_high_r1: assert property (@(posedge clk)
        rst |=> (pchk_n && pchk_oe));

    p_low_after_ready_r2: assert property (@(posedge clk) disable iff (rst)
        !pchk_n |-> $past(bus_active && !rdy_n));

    p_no_lanes_no_error_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_active && !rdy_n && (be == '0)) |=> pchk_n);

    p_idle_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        !bus_active |=> pchk_n);

    p_first_clock_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_active) |=> pchk_n);

    p_single_clock_r9: assert property (@(posedge clk) disable iff (rst)
        !pchk_n |=> pchk_n);

    p_hiz_off_r10: assert property (@(posedge clk) disable iff (rst)
        test_hiz |=> !pchk_oe);

    p_hiz_on_r10: assert property (@(posedge clk) disable iff (rst)
        !test_hiz |=> pchk_oe);

endmodule

bind rd_parity_status rd_parity_status_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_active (bus_active),
    .rdy_n      (rdy_n),
    .be         (be),
    .test_hiz   (test_hiz),
    .pchk_n     (pchk_n),
    .pchk_oe    (pchk_oe)
);

// File: tb/sim_rd_parity_status.sv
module sim_rd_parity_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_active = 1'b0;
    logic        is_write = 1'b0;
    logic        rdy_n = 1'b1;
    logic [3:0]  be = '0;
    logic        size8 = 1'b0;
    logic        size16 = 1'b0;
    logic [31:0] rdata = '0;
    logic [3:0]  rpar = '0;
    logic        test_hiz = 1'b0;
    logic        pchk_n;
    logic        pchk_oe;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    rd_parity_status #(.LANES(4)) u0 (
        .clk(clk), .rst(rst), .bus_active(bus_active), .is_write(is_write),
        .rdy_n(rdy_n), .be(be), .size8(size8), .size16(size16),
        .rdata(rdata), .rpar(rpar), .test_hiz(test_hiz),
        .pchk_n(pchk_n), .pchk_oe(pchk_oe)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // lanes expected to be checked: sz 0=32-bit, 1=8-bit, 2=16-bit, 3=both size inputs
    function automatic logic [3:0] exp_mask(input logic [3:0] b, input int sz);
        if (sz == 1 || sz == 3) return b & (~b + 4'd1);
        if (sz == 2) return (b[1:0] != 2'b00) ? (b & 4'h3) : (b & 4'hC);
        return b;
    endfunction

    task automatic run_cycle(input logic wr, input logic [3:0] b, input int sz,
                             input int err_lane, input logic flip_data,
                             input logic early, input int waits);
        logic [3:0] em;
        logic       exp_low;
        string      req;
        @(negedge clk);
        bus_active = 1'b1;
        is_write   = wr;
        be         = b;
        size8      = (sz == 1 || sz == 3);
        size16     = (sz == 2 || sz == 3);
        for (int l = 0; l < 4; l++) begin
            rdata[l*8 +: 8] = 8'((int'(b) * 37 + l * 91 + err_lane * 13 + 5) & 255);
            rpar[l] = ^rdata[l*8 +: 8];
        end
        if (err_lane < 4) begin
            if (flip_data) rdata[err_lane*8 + (int'(b) % 8)] = ~rdata[err_lane*8 + (int'(b) % 8)];
            else rpar[err_lane] = ~rpar[err_lane];
        end
        rdy_n = early ? 1'b0 : 1'b1;
        @(negedge clk);
        check(pchk_n, 1'b1, "R7 first clock");
        rdy_n = (waits == 0) ? 1'b0 : 1'b1;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            check(pchk_n, 1'b1, "R9 wait state");
            rdy_n = (i == waits - 1) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        bus_active = 1'b0;
        rdy_n      = 1'b1;
        em = exp_mask(b, sz);
        exp_low = !wr && (err_lane < 4) && em[err_lane];
        if (wr) req = "R8 write";
        else if (sz == 0) req = "R2/R3/R4 32-bit";
        else if (sz == 2) req = "R2/R3/R6 16-bit";
        else req = "R2/R3/R5 8-bit";
        check(pchk_n, !exp_low, req);
        @(negedge clk);
        check(pchk_n, 1'b1, "R9 after status");
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pchk_n, 1'b1, "R1 pchk_n in reset");
        check(pchk_oe, 1'b1, "R1 pchk_oe in reset");
        rst = 1'b0;
        @(negedge clk);
        check(pchk_n, 1'b1, "R1 pchk_n after reset");
        check(pchk_oe, 1'b1, "R1 pchk_oe after reset");

        // ready while idle, with bad parity on every lane
        be = 4'hF; rpar = 4'h0; rdata = 32'h0101_0101; rdy_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(pchk_n, 1'b1, "R7 idle ready");
        end
        rdy_n = 1'b1;

        // full sweep
        for (int wr = 0; wr < 2; wr++)
            for (int sz = 0; sz < 4; sz++)
                for (int b = 0; b < 16; b++)
                    for (int e = 0; e < 5; e++)
                        run_cycle(wr[0], 4'(b), sz, e, logic'((b + e) % 2),
                                  logic'(b % 2), (b + e) % 3);

        // aborted read: active drops before ready, then a clean new cycle
        @(negedge clk);
        bus_active = 1'b1; is_write = 1'b0; be = 4'hF; size8 = 1'b0; size16 = 1'b0;
        rdata = 32'h0; rpar = 4'hF; rdy_n = 1'b1;
        @(negedge clk);
        bus_active = 1'b0; rdy_n = 1'b0;
        @(negedge clk);
        check(pchk_n, 1'b1, "R11 abort no status");
        bus_active = 1'b1; rdy_n = 1'b0;
        @(negedge clk);
        check(pchk_n, 1'b1, "R11 new first clock ignores ready");
        rdy_n = 1'b0;
        @(negedge clk);
        bus_active = 1'b0; rdy_n = 1'b1;
        check(pchk_n, 1'b0, "R11/R2 new cycle completes");
        @(negedge clk);
        check(pchk_n, 1'b1, "R9 after abort test");

        // three-state test mode
        test_hiz = 1'b1;
        @(negedge clk);
        check(pchk_oe, 1'b0, "R10 enable off");
        @(negedge clk);
        check(pchk_oe, 1'b0, "R10 enable stays off");
        test_hiz = 1'b0;
        @(negedge clk);
        check(pchk_oe, 1'b1, "R10 enable back on");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule